// File: doc/BRIEF.md
# Record-Path Silence Gate

The block sits after the level detector and the automatic level controller of an audio record channel. For every sample it receives a strobe, a level reading and the gain that the level controller asks for. It decides when the channel counts as silent. A sample is quiet when its level is below a threshold that software programs in 1.5 dB steps. The gate activates only after a long unbroken run of quiet samples, set by the `HOLD_STROBES` parameter, which is 12000 strobes (250 ms at 48 kHz) by default.

Once active, the gate takes one of four actions, chosen by a 2-bit field. It can freeze the gain, mute the digital output, ramp the gain down to its floor, or ramp down and then mute. The first strobe whose level is at or above the threshold reopens the gate at once. Clearing the enable input also reopens it. While the gate is open, the gain passes through unchanged.

The controller is a single state machine with seven states:
- `ST_OPEN`: pass-through.
- `ST_HOLD`: frozen gain.
- `ST_MUTE`: digital mute.
- `ST_RAMP`: fading, no mute to follow.
- `ST_RAMP_M`: fading, mute to follow.
- `ST_FLOOR`: at the floor, unmuted.
- `ST_SILENT`: at the floor and muted.

Transitions:
- **trip**: `ST_OPEN` goes to the state the action selects, on the qualifying strobe. A fade goes straight to its floor state when the gain is already at the floor.
- **step**: a ramp state moves the gain down one code.
- **land**: `ST_RAMP` goes to `ST_FLOOR`, and `ST_RAMP_M` goes to `ST_SILENT`, when the step reaches the floor.
- **release**: any state goes to `ST_OPEN`, on a loud strobe or when the enable is cleared.

Top module: `noise_gate_ctrl`

## Requirements
- R1: After reset the gate is open: `active_o`=0, `mute_o`=0, and `gain_o` equals `gain_i`.
- R2: `lvl_i` is attenuation in 0.5 dB units, so a value v means -v/2 dBFS. A strobe is quiet when v > 153 - 3*`thr_i`. Code 0 is therefore -76.5 dB and code 31 is -30 dB. A level equal to the threshold is loud.
- R3: `active_o` rises in the clock edge of the `HOLD_STROBES`-th consecutive quiet strobe, and not on any earlier strobe.
- R4: A loud strobe restarts the quiet count, so a further `HOLD_STROBES` quiet strobes are needed.
- R5: With `en_i`=0 the gate never activates. Clearing `en_i` while the gate is active reopens it on the next clock edge.
- R6: Action 00 (hold): `gain_o` stays at the `gain_i` value present at activation, whatever `gain_i` does, and `mute_o` stays 0.
- R7: Action 01 (mute): `mute_o`=1 and `gain_o` keeps following `gain_i`.
- R8: Action 10 (fade): `gain_o` starts at the `gain_i` value present at activation. It drops by one code on every `FADE_STEP`-th quiet strobe after activation until it reaches `GAIN_MIN`, and stays there with `mute_o`=0. If `gain_i` is already at or below `GAIN_MIN` at activation, `gain_o` is `GAIN_MIN` at once.
- R9: Action 11 (fade then mute): the gain ramps as in R8. `mute_o` rises in the same clock edge in which `gain_o` reaches `GAIN_MIN`, and not before.
- R10: A loud strobe while the gate is active reopens it on that clock edge: `active_o`=0, `mute_o`=0 and `gain_o`=`gain_i`.
- R11: The action is taken from `act_i` at activation. Changes to `act_i` while the gate is active have no effect until the gate reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| stb_i | input | 1 | one-cycle sample strobe |
| lvl_i | input | LVL_W | sample level, attenuation in 0.5 dB units |
| gain_i | input | GAIN_W | gain requested by the level controller |
| en_i | input | 1 | gate enable |
| act_i | input | 2 | gate action: 00 hold, 01 mute, 10 fade, 11 fade then mute |
| thr_i | input | 5 | threshold code, 1.5 dB per step |
| gain_o | output | GAIN_W | gain to apply |
| mute_o | output | 1 | digital mute |
| active_o | output | 1 | gate engaged |

## Verification
The assertions assume that `lvl_i` and `thr_i` are stable and meaningful whenever `stb_i` is high. They also assume that `rst` is held for several cycles, so that `$past` terms see settled state. The bench meets both assumptions: it changes level and configuration only on falling edges, and it pulses the strobe for one cycle with the level already in place. The bench changes `act_i` and `gain_i` mid-gate on purpose, to show that the frozen and ramped gains ignore them. It never changes `thr_i` inside a qualification run.

// File: rtl/ng_pkg.sv
package ng_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD      = 2'b00,
        ACT_MUTE      = 2'b01,
        ACT_FADE      = 2'b10,
        ACT_FADE_MUTE = 2'b11
    } gate_act_e;

    typedef enum logic [2:0] {
        ST_OPEN,
        ST_HOLD,
        ST_MUTE,
        ST_RAMP,
        ST_RAMP_M,
        ST_FLOOR,
        ST_SILENT
    } gate_st_e;

    localparam int THR_BASE = 153;  // -76.5 dB in 0.5 dB units
    localparam int THR_STEP = 3;    // 1.5 dB per code

    function automatic int thr_att(input logic [4:0] code);
        return THR_BASE - THR_STEP * int'(code);
    endfunction

endpackage

// File: rtl/ng_level_cmp.sv
module ng_level_cmp #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [4:0]       thr_i,
    output logic             quiet_o
);
    always_comb begin
        quiet_o = int'(32'(lvl_i)) > ng_pkg::thr_att(thr_i);
    end
endmodule

// File: rtl/ng_qual_timer.sv
module ng_qual_timer #(
    parameter int HOLD_STROBES = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic stb_i,
    input  logic quiet_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(HOLD_STROBES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_STROBES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (stb_i) begin
            if (!quiet_i)
                cnt_q <= '0;
            else if (cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = en_i && stb_i && quiet_i && (cnt_q == LAST);
endmodule

// File: rtl/ng_fade_step.sv
module ng_fade_step #(
    parameter int FADE_STEP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic stb_i,
    output logic tick_o
);
    localparam int DIV_W = $clog2(FADE_STEP + 1);
    localparam logic [DIV_W-1:0] WRAP = DIV_W'(FADE_STEP - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            div_q <= '0;
        else if (stb_i)
            div_q <= (div_q == WRAP) ? '0 : div_q + 1'b1;
    end

    assign tick_o = run_i && stb_i && (div_q == WRAP);
endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl
    import ng_pkg::*;
#(
    parameter int LVL_W        = 8,
    parameter int GAIN_W       = 6,
    parameter int GAIN_MIN     = 0,
    parameter int HOLD_STROBES = 12000,
    parameter int FADE_STEP    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic              en_i,
    input  logic [1:0]        act_i,
    input  logic [4:0]        thr_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              mute_o,
    output logic              active_o
);
    localparam logic [GAIN_W-1:0] G_MIN  = GAIN_W'(GAIN_MIN);
    localparam logic [GAIN_W-1:0] G_LAND = GAIN_W'(GAIN_MIN + 1);

    gate_st_e          state_q, state_d;
    logic [GAIN_W-1:0] hold_q;
    logic [GAIN_W-1:0] fade_q;
    logic              quiet, expire, tick, ramping, trip;
    gate_act_e         act;

    assign act     = gate_act_e'(act_i);
    assign ramping = (state_q == ST_RAMP) || (state_q == ST_RAMP_M);
    assign trip    = (state_q == ST_OPEN) && expire;

    ng_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .lvl_i  (lvl_i),
        .thr_i  (thr_i),
        .quiet_o(quiet)
    );

    ng_qual_timer #(.HOLD_STROBES(HOLD_STROBES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .stb_i   (stb_i),
        .quiet_i (quiet),
        .expire_o(expire)
    );

    ng_fade_step #(.FADE_STEP(FADE_STEP)) u_step (
        .clk   (clk),
        .rst   (rst),
        .run_i (ramping),
        .stb_i (stb_i),
        .tick_o(tick)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!en_i || (stb_i && !quiet)) begin
            state_d = ST_OPEN;                       // release
        end else begin
            unique case (state_q)
                ST_OPEN: begin
                    if (expire) begin                // trip
                        unique case (act)
                            ACT_HOLD:      state_d = ST_HOLD;
                            ACT_MUTE:      state_d = ST_MUTE;
                            ACT_FADE:      state_d = (gain_i <= G_MIN) ? ST_FLOOR  : ST_RAMP;
                            ACT_FADE_MUTE: state_d = (gain_i <= G_MIN) ? ST_SILENT : ST_RAMP_M;
                            default:       state_d = ST_OPEN;
                        endcase
                    end
                end
                ST_RAMP:   if (tick && fade_q == G_LAND) state_d = ST_FLOOR;   // land
                ST_RAMP_M: if (tick && fade_q == G_LAND) state_d = ST_SILENT;  // land
                ST_HOLD, ST_MUTE, ST_FLOOR, ST_SILENT: state_d = state_q;
                default:   state_d = ST_OPEN;
            endcase
        end
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPEN;
            hold_q  <= '0;
            fade_q  <= '0;
        end else begin
            state_q <= state_d;
            if (trip) begin
                hold_q <= gain_i;
                fade_q <= gain_i;
            end else if (ramping && tick && fade_q > G_MIN) begin
                fade_q <= fade_q - 1'b1;             // step
            end
        end
    end

    // outputs
    always_comb begin
        gain_o   = gain_i;
        mute_o   = 1'b0;
        active_o = 1'b1;
        unique case (state_q)
            ST_OPEN:             active_o = 1'b0;
            ST_HOLD:             gain_o   = hold_q;
            ST_MUTE:             mute_o   = 1'b1;
            ST_RAMP, ST_RAMP_M:  gain_o   = fade_q;
            ST_FLOOR:            gain_o   = G_MIN;
            ST_SILENT: begin
                gain_o = G_MIN;
                mute_o = 1'b1;
            end
            default:             active_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ng_gate_chk.sv
module ng_gate_chk
    import ng_pkg::*;
#(
    parameter int LVL_W    = 8,
    parameter int GAIN_W   = 6,
    parameter int GAIN_MIN = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              stb_i,
    input logic [LVL_W-1:0]  lvl_i,
    input logic [GAIN_W-1:0] gain_i,
    input logic              en_i,
    input logic [4:0]        thr_i,
    input logic [GAIN_W-1:0] gain_o,
    input logic              mute_o,
    input logic              active_o,
    input gate_st_e          state_q
);
    logic loud_stb, fading;
    assign loud_stb = stb_i && (int'(32'(lvl_i)) <= thr_att(thr_i));
    assign fading   = (state_q == ST_RAMP) || (state_q == ST_RAMP_M) ||
                      (state_q == ST_FLOOR) || (state_q == ST_SILENT);

    p_open_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (gain_o == gain_i && !mute_o));

    p_trip_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> $past(stb_i));

    p_disable_r5: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !active_o);

    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> $stable(gain_o));

    p_mute_needs_gate_r7: assert property (@(posedge clk) disable iff (rst)
        mute_o |-> active_o);

    p_fade_down_r8: assert property (@(posedge clk) disable iff (rst)
        (fading && $past(fading)) |-> (gain_o <= $past(gain_o)));

    p_silent_floor_r9: assert property (@(posedge clk) disable iff (rst)
        (fading && mute_o) |-> (gain_o == GAIN_W'(GAIN_MIN)));

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        loud_stb |=> !active_o);
endmodule

bind noise_gate_ctrl ng_gate_chk #(
    .LVL_W(LVL_W), .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN)
) u_chk (
    .clk(clk), .rst(rst), .stb_i(stb_i), .lvl_i(lvl_i), .gain_i(gain_i),
    .en_i(en_i), .thr_i(thr_i), .gain_o(gain_o), .mute_o(mute_o),
    .active_o(active_o), .state_q(state_q)
);

// File: tb/sim_noise_gate_ctrl.sv
`timescale 1ns/1ps
module sim_noise_gate_ctrl;
    localparam int HOLD = 6;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic [7:0] lvl = '0;
    logic [5:0] gain = '0;
    logic       en = 1'b0;
    logic [1:0] act = 2'b00;
    logic [4:0] thr = '0;
    logic [5:0] gain_o;
    logic       mute_o, active_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    noise_gate_ctrl #(
        .LVL_W(8), .GAIN_W(6), .GAIN_MIN(0), .HOLD_STROBES(HOLD), .FADE_STEP(STEP)
    ) u0 (
        .clk(clk), .rst(rst), .stb_i(stb), .lvl_i(lvl), .gain_i(gain),
        .en_i(en), .act_i(act), .thr_i(thr),
        .gain_o(gain_o), .mute_o(mute_o), .active_o(active_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] l);
        @(negedge clk); lvl = l; stb = 1'b1;
        @(negedge clk); stb = 1'b0;
    endtask

    task automatic quiet_run(input int n, input logic [7:0] l);
        for (int i = 0; i < n; i++) strobe(l);
    endtask

    task automatic reopen();
        strobe(8'd0);
    endtask

    // {level, exp active, exp mute, exp gain}; act=11, thr=10 (quiet above 123), gain_i=3
    localparam logic [15:0] VEC [15] = '{
        {8'd130, 1'b0, 1'b0, 6'd3}, {8'd130, 1'b0, 1'b0, 6'd3},
        {8'd130, 1'b0, 1'b0, 6'd3}, {8'd130, 1'b0, 1'b0, 6'd3},
        {8'd124, 1'b0, 1'b0, 6'd3}, {8'd200, 1'b1, 1'b0, 6'd3},
        {8'd130, 1'b1, 1'b0, 6'd3}, {8'd130, 1'b1, 1'b0, 6'd2},
        {8'd130, 1'b1, 1'b0, 6'd2}, {8'd130, 1'b1, 1'b0, 6'd1},
        {8'd130, 1'b1, 1'b0, 6'd1}, {8'd130, 1'b1, 1'b1, 6'd0},
        {8'd130, 1'b1, 1'b1, 6'd0}, {8'd123, 1'b0, 1'b0, 6'd3},
        {8'd130, 1'b0, 1'b0, 6'd3}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        gain = 6'd17;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 active", active_o, 0);
        chk("R1 mute", mute_o, 0);
        chk("R1 gain", gain_o, 17);

        // table walk: fade then mute (R3, R9, R10, R2)
        en = 1'b1; act = 2'b11; thr = 5'd10; gain = 6'd3;
        for (int k = 0; k < 15; k++) begin
            strobe(VEC[k][15:8]);
            chk($sformatf("R9 vec%0d active", k), active_o, int'(VEC[k][7]));
            chk($sformatf("R9 vec%0d mute", k), mute_o, int'(VEC[k][6]));
            chk($sformatf("R10 vec%0d gain", k), gain_o, int'(VEC[k][5:0]));
        end
        reopen();

        // R2: boundary at thr=10 (123 loud)
        act = 2'b01;
        quiet_run(HOLD + 2, 8'd123);
        chk("R2 equal level is loud", active_o, 0);
        // R2: code 31 -> 60 half-dB
        thr = 5'd31;
        quiet_run(HOLD, 8'd60);
        chk("R2 code31 at -30dB loud", active_o, 0);
        quiet_run(HOLD, 8'd61);
        chk("R2 code31 below -30dB quiet", active_o, 1);
        reopen();
        // R2: code 0 -> 153
        thr = 5'd0;
        quiet_run(HOLD, 8'd153);
        chk("R2 code0 at -76.5dB loud", active_o, 0);
        quiet_run(HOLD, 8'd154);
        chk("R2 code0 below quiet", active_o, 1);
        reopen();

        // R3 / R4
        thr = 5'd10;
        quiet_run(HOLD - 1, 8'd200);
        chk("R3 one short", active_o, 0);
        strobe(8'd10);
        quiet_run(HOLD - 1, 8'd200);
        chk("R4 restart after loud", active_o, 0);
        strobe(8'd200);
        chk("R4 full run after loud", active_o, 1);
        reopen();

        // R5
        en = 1'b0;
        quiet_run(HOLD + 3, 8'd200);
        chk("R5 disabled never trips", active_o, 0);
        en = 1'b1;
        quiet_run(HOLD, 8'd200);
        chk("R5 enabled trips", active_o, 1);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R5 clear reopens", active_o, 0);
        en = 1'b1;

        // R6 hold, R11 act ignored
        act = 2'b00; gain = 6'd20;
        quiet_run(HOLD, 8'd200);
        chk("R6 active", active_o, 1);
        chk("R6 latched gain", gain_o, 20);
        gain = 6'd30; act = 2'b01;
        quiet_run(2, 8'd200);
        chk("R6 gain ignores input", gain_o, 20);
        chk("R11 act change no mute", mute_o, 0);
        reopen();
        chk("R10 reopen tracks", gain_o, 30);

        // R7 mute
        act = 2'b01; gain = 6'd9;
        quiet_run(HOLD, 8'd200);
        chk("R7 mute", mute_o, 1);
        @(negedge clk); gain = 6'd11;
        @(negedge clk);
        chk("R7 gain tracks", gain_o, 11);
        reopen();
        chk("R10 mute clears", mute_o, 0);

        // R8 fade only
        act = 2'b10; gain = 6'd2;
        quiet_run(HOLD, 8'd200);
        chk("R8 start", gain_o, 2);
        quiet_run(STEP, 8'd200);
        chk("R8 one step", gain_o, 1);
        quiet_run(STEP, 8'd200);
        chk("R8 floor", gain_o, 0);
        quiet_run(3, 8'd200);
        chk("R8 stays floor", gain_o, 0);
        chk("R8 no mute", mute_o, 0);
        reopen();
        gain = 6'd0;
        quiet_run(HOLD, 8'd200);
        chk("R8 already at floor active", active_o, 1);
        chk("R8 already at floor gain", gain_o, 0);
        reopen();

        // R9 floor at activation mutes at once
        act = 2'b11;
        quiet_run(HOLD, 8'd200);
        chk("R9 floor at trip mutes", mute_o, 1);
        reopen();

        summary();
        $finish;
    end
endmodule